// File: doc/BRIEF.md
# Direct-Mapped Write-Back Byte Cache Controller

This block sits between a processor byte bus and a main memory that is four times slower than the cache. It keeps sixteen one-byte lines. Each line has a four-bit tag, a valid bit and a modified bit. An eight-bit request address splits into a four-bit line index in the low bits and a four-bit tag in the high bits. Hits are served from the local store in one cycle. Writes stay in the cache and mark the line modified, so memory sees a write only when a modified line is evicted.

A one-hot controller decodes each request in its idle state. It then enters one of the following states: read hit, write hit, clean write miss, clean read miss, or write-back. Write-back handles a miss on a modified line. It first copies the victim byte to memory at the address built from the stored tag and the index. It then continues into the clean-miss state that matches the request. The processor holds a request with `cpu_req` until it sees `cpu_ack`, then lowers the request. Only one request is outstanding at a time.

Top module: `wb_cache_ctrl`

## Requirements
- R1: After reset the controller is idle, with `cpu_ack` and `mem_en` low. Every line is invalid, so the first access to any index misses.
- R2: A read whose tag matches a valid line returns the stored byte on `cpu_rdata` with `cpu_ack` in the cycle after the request is taken. No memory access takes place.
- R3: A write that hits stores `cpu_wdata` in the line, marks the line modified, and acknowledges one cycle after acceptance. It does not access memory.
- R4: A read miss on an unmodified or invalid line reads memory (`mem_en`=1, `mem_we`=0) at the request address. When `mem_rdy` arrives, that byte is returned with `cpu_ack` and filled into the line, which is left unmodified.
- R5: A write miss on an unmodified or invalid line fills the line with the write data and tag and marks it modified. It acknowledges one cycle after acceptance, with no memory access.
- R6: A miss on a valid modified line first writes the cached byte to memory (`mem_we`=1) at address {stored tag, index}. It clears the modified bit on `mem_rdy` and then proceeds to the R4 or R5 handling for the request.
- R7: Each request produces exactly one `cpu_ack` pulse, one cycle wide.
- R8: While `mem_en` is high and `mem_rdy` has not yet arrived, `mem_addr`, `mem_we` and `mem_wdata` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Request held until acknowledged |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 8 | Byte address, tag in [7:4], index in [3:0] |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, valid with cpu_ack |
| cpu_ack | output | 1 | One-cycle completion pulse |
| mem_addr | output | 8 | Memory address |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_en | output | 1 | Memory access request |
| mem_wdata | output | 8 | Byte written to memory |
| mem_rdata | input | 8 | Byte read from memory |
| mem_rdy | input | 1 | Memory completion |

## Verification
The stimulus covers the following cases:
- A cold read on an empty cache.
- Repeated reads and writes to one line.
- Write misses into empty lines.
- Misses of both directions on lines left modified.
- A sweep of every index with alternating tags.

The bench compares the acknowledge latency with its own model of the tags and modified bits. A hit takes 1 cycle, a clean read miss 4, a dirty write miss 5 and a dirty read miss 8. This separates hits from misses and shows whether a write-back was inserted. Evicted addresses are read back later. If the write-back used the wrong address or byte, the value returned differs from the expected memory contents. Counting memory writes confirms that clean misses and hits never write memory.

// File: rtl/wbc_pkg.sv
package wbc_pkg;

    typedef enum logic [4:0] {
        ST_IDLE    = 5'h00,
        ST_RD_HIT  = 5'h01,
        ST_WR_HIT  = 5'h02,
        ST_WBACK   = 5'h04,
        ST_WR_FILL = 5'h08,
        ST_RD_FILL = 5'h10
    } ctrl_state_e;

endpackage

// File: rtl/wbc_lookup.sv
module wbc_lookup #(
    parameter int TAG_W = 4
) (
    input  logic [TAG_W-1:0] req_tag,
    input  logic [TAG_W-1:0] line_tag,
    input  logic             line_valid,
    input  logic             line_dirty,
    output logic             hit,
    output logic             victim_dirty
);

    always_comb begin
        hit          = line_valid && (line_tag == req_tag);
        victim_dirty = line_valid && line_dirty && !hit;
    end

endmodule

// File: rtl/wbc_store.sv
module wbc_store #(
    parameter int IDX_W  = 4,
    parameter int TAG_W  = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  idx,
    input  logic              fill_en,
    input  logic              fill_dirty,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic [DATA_W-1:0] fill_data,
    input  logic              clean_en,
    output logic [DATA_W-1:0] line_data,
    output logic [TAG_W-1:0]  line_tag,
    output logic              line_valid,
    output logic              line_dirty
);

    localparam int DEPTH = 1 << IDX_W;

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] data;
        logic [DEPTH-1:0][TAG_W-1:0]  tag;
        logic [DEPTH-1:0]             valid;
        logic [DEPTH-1:0]             dirty;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (fill_en) begin
            st_d.data[idx]  = fill_data;
            st_d.tag[idx]   = fill_tag;
            st_d.valid[idx] = 1'b1;
            st_d.dirty[idx] = fill_dirty;
        end else if (clean_en) begin
            st_d.dirty[idx] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        line_data  = st_q.data[idx];
        line_tag   = st_q.tag[idx];
        line_valid = st_q.valid[idx];
        line_dirty = st_q.dirty[idx];
    end

    // R6: only a valid, modified line may be written back
    assert_wb_src_dirty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clean_en |-> (st_q.valid[idx] && st_q.dirty[idx]));

    // R1: fill and clean never requested together
    assert_fill_clean_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(fill_en && clean_en));

endmodule

// File: rtl/wbc_ctrl.sv
module wbc_ctrl
    import wbc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic we,
    input  logic hit,
    input  logic victim_dirty,
    input  logic mem_rdy,
    output logic cpu_ack,
    output logic mem_en,
    output logic mem_we,
    output logic use_mem_data,
    output logic wb_sel,
    output logic fill_en,
    output logic fill_dirty,
    output logic clean_en
);

    typedef struct packed {
        ctrl_state_e state;
    } ctrl_t;

    ctrl_t ct_d, ct_q;

    always_comb begin
        ct_d = ct_q;
        unique case (ct_q.state)
            ST_IDLE: begin
                if (req) begin
                    if (hit)               ct_d.state = we ? ST_WR_HIT : ST_RD_HIT;
                    else if (victim_dirty) ct_d.state = ST_WBACK;
                    else                   ct_d.state = we ? ST_WR_FILL : ST_RD_FILL;
                end
            end
            ST_RD_HIT, ST_WR_HIT, ST_WR_FILL: ct_d.state = ST_IDLE;
            ST_WBACK: begin
                if (mem_rdy) ct_d.state = we ? ST_WR_FILL : ST_RD_FILL;
            end
            ST_RD_FILL: begin
                if (mem_rdy) ct_d.state = ST_IDLE;
            end
            default: ct_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ct_q.state <= ST_IDLE;
        end else begin
            ct_q <= ct_d;
        end
    end

    always_comb begin
        cpu_ack      = (ct_q.state == ST_RD_HIT) || (ct_q.state == ST_WR_HIT) ||
                       (ct_q.state == ST_WR_FILL) ||
                       ((ct_q.state == ST_RD_FILL) && mem_rdy);
        mem_en       = (ct_q.state == ST_WBACK) || (ct_q.state == ST_RD_FILL);
        mem_we       = (ct_q.state == ST_WBACK);
        wb_sel       = (ct_q.state == ST_WBACK);
        use_mem_data = (ct_q.state == ST_RD_FILL);
        fill_en      = (ct_q.state == ST_WR_HIT) || (ct_q.state == ST_WR_FILL) ||
                       ((ct_q.state == ST_RD_FILL) && mem_rdy);
        fill_dirty   = (ct_q.state == ST_WR_HIT) || (ct_q.state == ST_WR_FILL);
        clean_en     = (ct_q.state == ST_WBACK) && mem_rdy;
    end

    // R1: at most one state bit set, idle is all zero
    assert_state_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ct_q.state));

    // R7: acknowledge never lasts two cycles
    assert_ack_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ack |=> !cpu_ack);

    // R2: a hit accepted in idle is acknowledged next cycle without memory
    assert_hit_fast_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ct_q.state == ST_IDLE && req && hit) |=> (cpu_ack && !mem_en));

endmodule

// File: rtl/wb_cache_ctrl.sv
module wb_cache_ctrl #(
    parameter int IDX_W  = 4,
    parameter int TAG_W  = 4,
    parameter int DATA_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cpu_req,
    input  logic                      cpu_we,
    input  logic [IDX_W+TAG_W-1:0]    cpu_addr,
    input  logic [DATA_W-1:0]         cpu_wdata,
    output logic [DATA_W-1:0]         cpu_rdata,
    output logic                      cpu_ack,
    output logic [IDX_W+TAG_W-1:0]    mem_addr,
    output logic                      mem_we,
    output logic                      mem_en,
    output logic [DATA_W-1:0]         mem_wdata,
    input  logic [DATA_W-1:0]         mem_rdata,
    input  logic                      mem_rdy
);

    localparam int ADDR_W = IDX_W + TAG_W;

    logic [IDX_W-1:0]  req_idx;
    logic [TAG_W-1:0]  req_tag;
    logic [DATA_W-1:0] line_data;
    logic [TAG_W-1:0]  line_tag;
    logic              line_valid, line_dirty;
    logic              hit, victim_dirty;
    logic              use_mem_data, wb_sel;
    logic              fill_en, fill_dirty, clean_en;
    logic [DATA_W-1:0] fill_data;

    assign req_idx = cpu_addr[IDX_W-1:0];
    assign req_tag = cpu_addr[ADDR_W-1:IDX_W];

    wbc_lookup #(.TAG_W(TAG_W)) u_lookup (
        .req_tag      (req_tag),
        .line_tag     (line_tag),
        .line_valid   (line_valid),
        .line_dirty   (line_dirty),
        .hit          (hit),
        .victim_dirty (victim_dirty)
    );

    wbc_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .idx        (req_idx),
        .fill_en    (fill_en),
        .fill_dirty (fill_dirty),
        .fill_tag   (req_tag),
        .fill_data  (fill_data),
        .clean_en   (clean_en),
        .line_data  (line_data),
        .line_tag   (line_tag),
        .line_valid (line_valid),
        .line_dirty (line_dirty)
    );

    wbc_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .req          (cpu_req),
        .we           (cpu_we),
        .hit          (hit),
        .victim_dirty (victim_dirty),
        .mem_rdy      (mem_rdy),
        .cpu_ack      (cpu_ack),
        .mem_en       (mem_en),
        .mem_we       (mem_we),
        .use_mem_data (use_mem_data),
        .wb_sel       (wb_sel),
        .fill_en      (fill_en),
        .fill_dirty   (fill_dirty),
        .clean_en     (clean_en)
    );

    always_comb begin
        fill_data = use_mem_data ? mem_rdata : cpu_wdata;
        cpu_rdata = use_mem_data ? mem_rdata : line_data;
        mem_addr  = wb_sel ? {line_tag, req_idx} : cpu_addr;
        mem_wdata = line_data;
    end

    // R8: memory request held steady until ready
    assert_mem_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && !mem_rdy) |=> (mem_en && $stable(mem_addr) &&
                                  $stable(mem_we) && $stable(mem_wdata)));

    // R6: a finished write-back chains into a read fill or a write fill
    assert_wb_chain_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && mem_we && mem_rdy) |=> ((mem_en && !mem_we) || (cpu_ack && !mem_en)));

    // R4: a finished memory read returns its byte with the acknowledge
    assert_rd_fill_ret_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && !mem_we && mem_rdy) |-> (cpu_ack && cpu_rdata == mem_rdata));

endmodule

// File: tb/wb_cache_ctrl_bench.sv
`timescale 1ns/1ps
module wb_cache_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_req = 1'b0, cpu_we = 1'b0;
    logic [7:0] cpu_addr = '0, cpu_wdata = '0;
    logic [7:0] cpu_rdata;
    logic       cpu_ack;
    logic [7:0] mem_addr, mem_wdata, mem_rdata;
    logic       mem_we, mem_en;
    logic       mem_rdy = 1'b0;

    always #5 clk = ~clk;

    wb_cache_ctrl u_wb_cache_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ack(cpu_ack),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_en(mem_en),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_rdy(mem_rdy)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [7:0] memarr  [256];
    logic [7:0] ref_mem [256];
    bit         rv [16];
    bit         rdt[16];
    logic [3:0] rt [16];
    int         mem_writes = 0;
    int         exp_writes = 0;

    typedef struct {
        bit         we;
        logic [7:0] addr;
        logic [7:0] data;
        int         lat;
        string      req;
    } item_t;
    item_t sb[$];

    assign mem_rdata = memarr[mem_addr];

    // memory model: ready three edges after the request appears
    initial begin
        int         cnt;
        logic [7:0] a0;
        logic       w0;
        logic [7:0] d0;
        cnt = 0; a0 = '0; w0 = 1'b0; d0 = '0;
        forever begin
            @(posedge clk);
            if (!rst_n) begin
                mem_rdy <= 1'b0; cnt = 0;
            end else if (mem_rdy) begin
                mem_rdy <= 1'b0; cnt = 0;
            end else if (mem_en) begin
                if (cnt == 0) begin
                    a0 = mem_addr; w0 = mem_we; d0 = mem_wdata;
                end
                if (cnt == 2) begin
                    mem_rdy <= 1'b1;
                    checks++;
                    if (mem_addr !== a0 || mem_we !== w0 || (w0 && mem_wdata !== d0)) begin
                        fails++;
                        $display("FAIL R8 request moved: addr %h we %b exp addr %h we %b",
                                 mem_addr, mem_we, a0, w0);
                    end
                    if (mem_we) begin
                        memarr[mem_addr] = mem_wdata;
                        mem_writes++;
                    end
                end else begin
                    cnt++;
                end
            end
        end
    end

    // monitor: pops expected items on each acknowledge
    initial begin
        int    lat;
        item_t it;
        lat = 0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (cpu_req) lat++;
                if (cpu_ack) begin
                    checks++;
                    if (sb.size() == 0) begin
                        fails++;
                        $display("FAIL R7 acknowledge with no request: act 1 exp 0");
                    end else begin
                        it = sb.pop_front();
                        if (lat != it.lat) begin
                            fails++;
                            $display("FAIL %s latency addr %h: act %0d exp %0d",
                                     it.req, it.addr, lat, it.lat);
                        end
                        if (!it.we) begin
                            checks++;
                            if (cpu_rdata !== it.data) begin
                                fails++;
                                $display("FAIL %s read data addr %h: act %h exp %h",
                                         it.req, it.addr, cpu_rdata, it.data);
                            end
                        end
                    end
                    lat = 0;
                end
            end
        end
    end

    // driver: model the expected outcome, push it, run the handshake
    task automatic access(input bit we, input logic [7:0] a, input logic [7:0] wd);
        item_t      it;
        logic [3:0] ix, tg;
        bit         h, wb;
        int         n;
        ix = a[3:0]; tg = a[7:4];
        h  = rv[ix] && (rt[ix] == tg);
        wb = rv[ix] && rdt[ix] && !h;
        it.we = we; it.addr = a; it.data = ref_mem[a];
        if (h) begin
            it.lat = 1; it.req = we ? "R3" : "R2";
        end else if (wb) begin
            it.lat = we ? 5 : 8; it.req = "R6"; exp_writes++;
        end else begin
            it.lat = we ? 1 : 4; it.req = we ? "R5" : "R4";
        end
        if (we) begin
            ref_mem[a] = wd; rdt[ix] = 1'b1;
        end else if (!h) begin
            rdt[ix] = 1'b0;
        end
        rv[ix] = 1'b1; rt[ix] = tg;
        sb.push_back(it);
        @(negedge clk); #1;
        cpu_we = we; cpu_addr = a; cpu_wdata = wd; cpu_req = 1'b1;
        n = 0;
        do begin
            @(negedge clk); #1;
            n++;
        end while (!cpu_ack && n < 60);
        if (!cpu_ack) begin
            checks++; fails++;
            $display("FAIL R7 no acknowledge addr %h: act 0 exp 1", a);
        end
        cpu_req = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #1_500_000;
        checks++; fails++;
        $display("FAIL watchdog expired: act hung exp finished");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            memarr[i]  = 8'((i * 37 + 11) & 8'hFF);
            ref_mem[i] = memarr[i];
        end
        for (int i = 0; i < 16; i++) begin
            rv[i] = 1'b0; rdt[i] = 1'b0; rt[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (cpu_ack !== 1'b0 || mem_en !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset outputs: act ack %b en %b exp 0 0", cpu_ack, mem_en);
        end
        // R1 cold miss, then R2 hit on the filled line
        access(1'b0, 8'h35, 8'h00);
        access(1'b0, 8'h35, 8'h00);
        // R3 write hit, read back
        access(1'b1, 8'h35, 8'hA1);
        access(1'b0, 8'h35, 8'h00);
        // R5 write miss into empty line, then hit
        access(1'b1, 8'h47, 8'h3C);
        access(1'b0, 8'h47, 8'h00);
        // R6 dirty read miss, then reload evicted byte from memory
        access(1'b0, 8'h75, 8'h00);
        access(1'b0, 8'h35, 8'h00);
        // R6 dirty write miss, then dirty read miss on the same line
        access(1'b1, 8'h97, 8'h5E);
        access(1'b0, 8'h47, 8'h00);
        access(1'b0, 8'h97, 8'h00);
        // sweep every index with alternating tags and directions
        for (int i = 0; i < 16; i++) begin
            access(1'b0, {4'hE, 4'(i)}, 8'h00);
            access(1'b1, {4'h2, 4'(i)}, 8'((i * 13) ^ 8'h5A));
            access(1'b0, {4'hE, 4'(i)}, 8'h00);
            access(1'b0, {4'h2, 4'(i)}, 8'h00);
        end
        repeat (4) @(negedge clk);
        checks++;
        if (sb.size() != 0) begin
            fails++;
            $display("FAIL R7 pending items: act %0d exp 0", sb.size());
        end
        // R6 memory is written only by write-backs (R3, R5 never write)
        checks++;
        if (mem_writes != exp_writes) begin
            fails++;
            $display("FAIL R6 memory write count: act %0d exp %0d", mem_writes, exp_writes);
        end
        finish_run();
    end

endmodule